// File: doc/BRIEF.md
# Staging-to-Endpoint Packet Loader

This block drains a shared staging FIFO into the transmit FIFOs of a set of USB-style endpoints and paces the loading against the endpoint's packet handshake. Software arms one endpoint at a time with a byte count and a termination choice. The loader serves one armed endpoint at a time. It copies bytes from the staging stream to the endpoint stream in blocks of `BLK_BYTES`. It stops when a packet of `MAX_PKT` bytes, or the shorter tail of the transfer, has been loaded, and then raises that endpoint's packet-ready flag.

While the flag is high, that endpoint receives nothing. When the USB core has sent the packet, it pulses the endpoint's request line. This clears the flag and makes the endpoint eligible for its next packet. At the end of a transfer, an optional zero-length packet marks a transfer that ended on a packet boundary. A completion pulse then frees the endpoint.

Both data interfaces are valid/ready and pass straight through while an endpoint is being loaded. `ep_valid` follows `in_valid`, and `in_ready` follows `ep_ready`, so back-pressure from the endpoint side stalls the staging side in the same cycle. A byte moves only in a cycle in which `ep_valid` and `ep_ready` are both high. While no endpoint is being loaded, both `in_ready` and `ep_valid` stay low.

Top module: `epfill_dma`

## Requirements
- R1: After reset, `busy`, `pkt_rdy` and `done` are all zero, and `in_ready` and `ep_valid` are low.
- R2: A `cfg_valid` cycle aimed at an endpoint whose `busy` bit is low arms it with `cfg_len` bytes and sets `busy` one cycle later. A `cfg_valid` cycle aimed at a busy endpoint is ignored and changes none of its packet sizes.
- R3: Bytes leave on `ep_data` in the order they were accepted on `in_data`, unmodified, with `ep_sel` holding the binary index of the endpoint being loaded. `ep_sel` does not change while a byte is stalled by `ep_ready` low.
- R4: Each packet carries min(remaining bytes, `MAX_PKT`) bytes. The endpoint's `pkt_rdy` bit rises in the cycle after the handshake of the packet's last byte.
- R5: `ep_blk_end` is high with a byte exactly when that byte is at position `BLK_BYTES`-1 modulo `BLK_BYTES` within its packet, or is the packet's last byte.
- R6: While an endpoint's `pkt_rdy` is high, no byte is sent to it. A one-cycle pulse on its `dma_req` bit clears `pkt_rdy` at the next clock edge.
- R7: A `dma_req` pulse for an endpoint whose `pkt_rdy` is low has no effect: it neither arms, completes nor shortens anything.
- R8: With `cfg_zlp` = 0, no packet follows the one that exhausts the byte count. With `cfg_zlp` = 1, one extra zero-length packet follows when the length is a non-zero multiple of `MAX_PKT`. A length of zero always yields a single zero-length packet.
- R9: The `dma_req` pulse that acknowledges a transfer's final packet clears `busy` and produces a one-cycle `done` pulse for that endpoint at the same edge. Earlier acknowledgements leave `busy` high and `done` low.
- R10: When the loader is free, it picks the lowest-numbered endpoint waiting for a packet load. Each packet is loaded to the end before another endpoint is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Arm request for endpoint `cfg_ep` |
| cfg_ep | input | IDX_W | Endpoint index to arm |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_zlp | input | 1 | Termination mode: 1 adds a zero-length packet after an exact-multiple transfer |
| dma_req | input | N | Per-endpoint "packet sent" pulse from the USB core |
| in_valid | input | 1 | Staging FIFO not empty |
| in_ready | output | 1 | Byte taken from the staging FIFO |
| in_data | input | DATA_W | Staging FIFO head byte |
| ep_valid | output | 1 | Byte offered to the endpoint FIFO |
| ep_ready | input | 1 | Endpoint FIFO can accept |
| ep_data | output | DATA_W | Byte to the endpoint FIFO |
| ep_sel | output | IDX_W | Endpoint being loaded |
| ep_blk_end | output | 1 | Byte closes a block |
| pkt_rdy | output | N | Per-endpoint transmit-packet-ready flag |
| busy | output | N | Endpoint armed and not yet finished |
| done | output | N | One-cycle transfer completion pulse |

## Verification
The bench sweeps every length from zero to a little over two packets in both termination modes, on a small configuration, while the staging and endpoint sides stall on unrelated rhythms. The packet sizes it expects are computed arithmetically from the length. A loader that miscounted its tail would report a short or long packet. One that tested for the exact multiple wrongly would emit a spurious zero-length packet, or omit one, which the bench sees as a wrong packet count or a late `done`. Block markers are checked on every byte, so an off-by-one reload of the block counter shows at the packet's tail.

Three endpoints are armed out of order while the staging side is held empty. This exposes an arbiter that favours arrival order or high indices. The same step checks that a request pulse to an endpoint still loading, or a second arm to a busy endpoint, leaves the packet sizes untouched.

// File: rtl/epfill_pkg.sv
package epfill_pkg;
  typedef enum logic [1:0] {
    CH_IDLE,
    CH_DUE,
    CH_LOAD,
    CH_HOLD
  } ch_phase_e;

  typedef enum logic {
    ENG_IDLE,
    ENG_MOVE
  } eng_state_e;
endpackage

// File: rtl/epfill_chan.sv
module epfill_chan
  import epfill_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_zlp,
  input  logic             grant,
  input  logic             byte_tk,
  input  logic             pkt_end,
  input  logic             pkt_full,
  input  logic             dma_req,
  output logic             due,
  output logic             busy,
  output logic             pkt_rdy,
  output logic             done,
  output logic [LEN_W-1:0] rem
);
  ch_phase_e phase;
  logic      zlp_mode;
  logic      last_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= CH_IDLE;
      rem       <= '0;
      zlp_mode  <= 1'b0;
      last_full <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        CH_IDLE: begin
          if (cfg_we) begin
            rem       <= cfg_len;
            zlp_mode  <= cfg_zlp;
            last_full <= 1'b0;
            phase     <= CH_DUE;
          end
        end
        CH_DUE: begin
          if (grant) phase <= CH_LOAD;
        end
        CH_LOAD: begin
          if (byte_tk) rem <= rem - LEN_W'(1);
          if (pkt_end) begin
            last_full <= pkt_full;
            phase     <= CH_HOLD;
          end
        end
        CH_HOLD: begin
          if (dma_req) begin
            if (rem != '0 || (zlp_mode && last_full)) begin
              phase <= CH_DUE;
            end else begin
              phase <= CH_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: phase <= CH_IDLE;
      endcase
    end
  end

  assign due     = (phase == CH_DUE);
  assign busy    = (phase != CH_IDLE);
  assign pkt_rdy = (phase == CH_HOLD);
endmodule

// File: rtl/epfill_arb.sv
module epfill_arb #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/epfill_mover.sv
module epfill_mover
  import epfill_pkg::*;
#(
  parameter int N         = 8,
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_PKT   = 512,
  parameter int BLK_BYTES = 64,
  parameter int IDX_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              due_any,
  input  logic [IDX_W-1:0]  due_idx,
  input  logic [LEN_W-1:0]  rem_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              ep_valid,
  input  logic              ep_ready,
  output logic [DATA_W-1:0] ep_data,
  output logic [IDX_W-1:0]  ep_sel,
  output logic              ep_blk_end,
  output logic [N-1:0]      grant,
  output logic [N-1:0]      byte_tk,
  output logic [N-1:0]      pkt_end,
  output logic              pkt_full
);
  localparam int PKT_W = $clog2(MAX_PKT + 1);
  localparam int BLK_W = $clog2(BLK_BYTES + 1);

  eng_state_e       state;
  logic [IDX_W-1:0] cur;
  logic [PKT_W-1:0] pkt_left;
  logic [PKT_W-1:0] first_len;
  logic [BLK_W-1:0] blk_left;
  logic             full_q;
  logic             moving;
  logic             hs;
  logic             end_now;

  function automatic logic [BLK_W-1:0] blk_of(input logic [PKT_W-1:0] n);
    return (n >= PKT_W'(BLK_BYTES)) ? BLK_W'(BLK_BYTES) : BLK_W'(n);
  endfunction

  always_comb begin
    if (rem_sel >= LEN_W'(MAX_PKT)) first_len = PKT_W'(MAX_PKT);
    else                            first_len = PKT_W'(rem_sel);
  end

  assign moving     = (state == ENG_MOVE) && (pkt_left != '0);
  assign hs         = moving && in_valid && ep_ready;
  assign end_now    = (state == ENG_MOVE) &&
                      ((pkt_left == '0) || (hs && pkt_left == PKT_W'(1)));
  assign ep_valid   = moving && in_valid;
  assign in_ready   = moving && ep_ready;
  assign ep_data    = in_data;
  assign ep_sel     = cur;
  assign ep_blk_end = ep_valid && (blk_left == BLK_W'(1));
  assign pkt_full   = full_q;

  for (genvar g = 0; g < N; g++) begin : g_evt
    assign grant[g]   = (state == ENG_IDLE) && due_any && (due_idx == IDX_W'(g));
    assign byte_tk[g] = hs && (cur == IDX_W'(g));
    assign pkt_end[g] = end_now && (cur == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      cur      <= '0;
      pkt_left <= '0;
      blk_left <= '0;
      full_q   <= 1'b0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (due_any) begin
            cur      <= due_idx;
            pkt_left <= first_len;
            blk_left <= blk_of(first_len);
            full_q   <= (rem_sel >= LEN_W'(MAX_PKT));
            state    <= ENG_MOVE;
          end
        end
        ENG_MOVE: begin
          if (end_now) begin
            state <= ENG_IDLE;
          end else if (hs) begin
            pkt_left <= pkt_left - PKT_W'(1);
            if (blk_left == BLK_W'(1)) blk_left <= blk_of(pkt_left - PKT_W'(1));
            else                       blk_left <= blk_left - BLK_W'(1);
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epfill_dma.sv
module epfill_dma #(
  parameter int N         = 8,
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 8,
  parameter int MAX_PKT   = 512,
  parameter int BLK_BYTES = 64,
  localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [IDX_W-1:0]  cfg_ep,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_zlp,
  input  logic [N-1:0]      dma_req,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              ep_valid,
  input  logic              ep_ready,
  output logic [DATA_W-1:0] ep_data,
  output logic [IDX_W-1:0]  ep_sel,
  output logic              ep_blk_end,
  output logic [N-1:0]      pkt_rdy,
  output logic [N-1:0]      busy,
  output logic [N-1:0]      done
);
  logic [N-1:0]     due;
  logic [N-1:0]     grant;
  logic [N-1:0]     byte_tk;
  logic [N-1:0]     pkt_end;
  logic             pkt_full;
  logic             due_any;
  logic [IDX_W-1:0] due_idx;
  logic [LEN_W-1:0] rem_a [N];
  logic [LEN_W-1:0] rem_sel;

  for (genvar g = 0; g < N; g++) begin : g_ch
    epfill_chan #(.LEN_W(LEN_W)) i_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_valid && cfg_ep == IDX_W'(g)),
      .cfg_len  (cfg_len),
      .cfg_zlp  (cfg_zlp),
      .grant    (grant[g]),
      .byte_tk  (byte_tk[g]),
      .pkt_end  (pkt_end[g]),
      .pkt_full (pkt_full),
      .dma_req  (dma_req[g]),
      .due      (due[g]),
      .busy     (busy[g]),
      .pkt_rdy  (pkt_rdy[g]),
      .done     (done[g]),
      .rem      (rem_a[g])
    );
  end

  epfill_arb #(.N(N), .IDX_W(IDX_W)) i_arb (
    .req (due),
    .any (due_any),
    .idx (due_idx)
  );

  assign rem_sel = rem_a[due_idx];

  epfill_mover #(
    .N(N), .LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_PKT(MAX_PKT),
    .BLK_BYTES(BLK_BYTES), .IDX_W(IDX_W)
  ) i_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .due_any    (due_any),
    .due_idx    (due_idx),
    .rem_sel    (rem_sel),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .ep_valid   (ep_valid),
    .ep_ready   (ep_ready),
    .ep_data    (ep_data),
    .ep_sel     (ep_sel),
    .ep_blk_end (ep_blk_end),
    .grant      (grant),
    .byte_tk    (byte_tk),
    .pkt_end    (pkt_end),
    .pkt_full   (pkt_full)
  );
endmodule

// File: rtl/epfill_dma_chk.sv
module epfill_dma_chk #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     dma_req,
  input logic             ep_valid,
  input logic             ep_ready,
  input logic [IDX_W-1:0] ep_sel,
  input logic [N-1:0]     pkt_rdy,
  input logic [N-1:0]     busy,
  input logic [N-1:0]     done
);
  // R6
  rdy_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep_valid |-> !pkt_rdy[ep_sel]);

  // R3
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_valid && !ep_ready) |=> $stable(ep_sel));

  // R6
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pkt_rdy) & ~pkt_rdy & ~$past(dma_req)) == '0));

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(pkt_rdy & dma_req)) == '0));

  // R9
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & busy) == '0));

  // R10
  one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pkt_rdy & ~$past(pkt_rdy)));
endmodule

bind epfill_dma epfill_dma_chk #(.N(N), .IDX_W(IDX_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dma_req  (dma_req),
  .ep_valid (ep_valid),
  .ep_ready (ep_ready),
  .ep_sel   (ep_sel),
  .pkt_rdy  (pkt_rdy),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_epfill_dma.sv
module test_epfill_dma;
  localparam int CLK_PERIOD = 10;
  localparam int N      = 8;
  localparam int LEN_W  = 16;
  localparam int DATA_W = 8;
  localparam int MAXP   = 8;
  localparam int BLK    = 4;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_valid = 1'b0;
  logic [IDX_W-1:0]  cfg_ep = '0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic              cfg_zlp = 1'b0;
  logic [N-1:0]      dma_req = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              ep_valid;
  logic              ep_ready = 1'b0;
  logic [DATA_W-1:0] ep_data;
  logic [IDX_W-1:0]  ep_sel;
  logic              ep_blk_end;
  logic [N-1:0]      pkt_rdy;
  logic [N-1:0]      busy;
  logic [N-1:0]      done;

  epfill_dma #(.N(N), .LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_PKT(MAXP), .BLK_BYTES(BLK))
    i_epfill_dma (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, mon_chk = 0, mon_fail = 0;
  int cyc = 0;
  bit hs_seen = 0;
  bit stall_in = 1'b0;
  int exp_ep = -1;
  logic [DATA_W-1:0] exp_byte = '0;
  int cur_pkt_len [N];
  int byte_tot [N];
  int pos_in [N];
  int ord_list [256];
  int ord_n = 0;
  int m_e;
  bit m_last, m_be;

  // stimulus for the stream inputs, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (hs_seen) in_data = in_data + 1'b1;
    in_valid = !stall_in && (cyc % 5 != 3);
    ep_ready = (cyc % 7 != 2);
  end

  // byte monitor, sampled at the falling edge
  always @(negedge clk) begin
    hs_seen = 0;
    if (rst_n && ep_valid && ep_ready) begin
      hs_seen = 1;
      m_e = int'(ep_sel);
      mon_chk++;
      if (ep_data !== exp_byte) begin
        mon_fail++;
        $display("FAIL R3 data act=%0d exp=%0d", ep_data, exp_byte);
      end
      exp_byte = exp_byte + 1'b1;
      if (exp_ep >= 0) begin
        mon_chk++;
        if (m_e != exp_ep) begin
          mon_fail++;
          $display("FAIL R3 ep_sel act=%0d exp=%0d", m_e, exp_ep);
        end
      end
      m_last = (pos_in[m_e] + 1 == cur_pkt_len[m_e]);
      m_be = m_last || (pos_in[m_e] % BLK == BLK - 1);
      mon_chk++;
      if (ep_blk_end !== m_be) begin
        mon_fail++;
        $display("FAIL R5 blk_end act=%0d exp=%0d", ep_blk_end, m_be);
      end
      if (pos_in[m_e] == 0) begin
        ord_list[ord_n % 256] = m_e;
        ord_n++;
      end
      pos_in[m_e] = m_last ? 0 : pos_in[m_e] + 1;
      byte_tot[m_e]++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic arm(input int ep, input int len, input bit mode);
    @(posedge clk); #1;
    cfg_valid = 1'b1; cfg_ep = IDX_W'(ep); cfg_len = LEN_W'(len); cfg_zlp = mode;
    @(posedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    @(posedge clk); #1;
    dma_req = m;
    @(posedge clk); #1;
    dma_req = '0;
  endtask

  task automatic wait_mask(input logic [N-1:0] m, output bit ok);
    ok = 0;
    for (int t = 0; t < 600; t++) begin
      @(negedge clk);
      if ((pkt_rdy & m) == m) begin ok = 1; break; end
    end
  endtask

  task automatic run_xfer(input int ep, input int len, input bit mode);
    int npk, rem, sz, base;
    bit ok;
    npk = (len == 0) ? 1 : (len + MAXP - 1) / MAXP + ((mode && len % MAXP == 0) ? 1 : 0);
    rem = len;
    exp_ep = ep;
    sz = (rem < MAXP) ? rem : MAXP;
    cur_pkt_len[ep] = sz;
    base = byte_tot[ep];
    arm(ep, len, mode);
    for (int p = 0; p < npk; p++) begin
      wait_mask(N'(1) << ep, ok);
      chk(ok, "R4 pkt_rdy timeout", int'(pkt_rdy[ep]), 1);
      chk(byte_tot[ep] - base == sz, (sz == 0 && len > 0) ? "R8 zlp size" : "R4 pkt size",
          byte_tot[ep] - base, sz);
      repeat (3) @(negedge clk);
      chk(byte_tot[ep] - base == sz && pkt_rdy[ep], "R6 hold", byte_tot[ep] - base, sz);
      base = base + sz;
      rem = rem - sz;
      sz = (rem < MAXP) ? rem : MAXP;
      cur_pkt_len[ep] = sz;
      pulse_req(N'(1) << ep);
      @(negedge clk);
      chk(!pkt_rdy[ep], "R6 clear", int'(pkt_rdy[ep]), 0);
      if (p == npk - 1) chk(done[ep] && !busy[ep], "R9 final", int'(done[ep]), 1);
      else              chk(!done[ep] && busy[ep], "R9 mid", int'(done[ep]), 0);
    end
    repeat (6) @(negedge clk);
    chk(!pkt_rdy[ep] && byte_tot[ep] == base && !busy[ep], "R8 no extra packet",
        byte_tot[ep] - base, 0);
  endtask

  task automatic prio_test();
    int ob;
    int b1, b3, b6;
    bit ok;
    stall_in = 1'b1;
    exp_ep = -1;
    cur_pkt_len[6] = MAXP; cur_pkt_len[3] = MAXP; cur_pkt_len[1] = MAXP;
    b1 = byte_tot[1]; b3 = byte_tot[3]; b6 = byte_tot[6];
    arm(6, MAXP, 1'b0);
    arm(3, MAXP, 1'b0);
    arm(1, MAXP, 1'b0);
    arm(1, 3, 1'b0);
    repeat (3) @(negedge clk);
    pulse_req(8'b0100_0000);
    @(negedge clk);
    chk(busy == 8'b0100_1010, "R2 armed set", int'(busy), 'h4a);
    chk(pkt_rdy == '0, "R7 req while loading", int'(pkt_rdy), 0);
    ob = ord_n;
    stall_in = 1'b0;
    wait_mask(8'b0100_1010, ok);
    chk(ok, "R10 all ready", int'(pkt_rdy), 'h4a);
    chk(ord_n - ob == 3, "R10 packet count", ord_n - ob, 3);
    chk(ord_list[ob % 256] == 6, "R10 first", ord_list[ob % 256], 6);
    chk(ord_list[(ob + 1) % 256] == 1, "R10 second", ord_list[(ob + 1) % 256], 1);
    chk(ord_list[(ob + 2) % 256] == 3, "R10 third", ord_list[(ob + 2) % 256], 3);
    chk(byte_tot[1] - b1 == MAXP, "R2 busy cfg ignored", byte_tot[1] - b1, MAXP);
    chk(byte_tot[3] - b3 == MAXP, "R4 ep3 size", byte_tot[3] - b3, MAXP);
    chk(byte_tot[6] - b6 == MAXP, "R7 ep6 size", byte_tot[6] - b6, MAXP);
    pulse_req(8'b0100_1010);
    @(negedge clk);
    chk(done == 8'b0100_1010, "R9 multi done", int'(done), 'h4a);
    chk(busy == '0, "R9 multi busy", int'(busy), 0);
  endtask

  initial begin
    bit wd;
    wd = 0;
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy == '0 && pkt_rdy == '0 && done == '0, "R1 flags", int'(busy | pkt_rdy | done), 0);
        chk(!ep_valid && !in_ready, "R1 stream idle", int'({ep_valid, in_ready}), 0);
        pulse_req(8'b0000_1000);
        @(negedge clk);
        chk(!busy[3] && !done[3] && !pkt_rdy[3], "R7 idle req", int'(busy[3]), 0);
        for (int md = 0; md < 2; md++) begin
          for (int len = 0; len < 20; len++) begin
            run_xfer(len % N, len, md[0]);
          end
        end
        prio_test();
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end
endmodule